// File: doc/BRIEF.md
# Parity-Transform Corrector for Four Parallel FFT Lanes

This block protects four FFTs that run side by side on independent sample streams. It builds the input of one extra transform, the parity FFT, by adding the four lane inputs sample by sample. It then takes the four lane outputs and the parity output and holds them for one frame, because the three energy-check flags that report on a frame are only known after that frame has ended. The external energy accumulators and the five FFTs are not part of the block.

The three flags act as the check bits of a Hamming code over the four lanes. Each flag covers three lanes, and the combination of raised flags points to the faulty lane. When a lane is named, the block discards that lane's stored output and rebuilds it as the parity output minus the other three lane outputs. All other lanes pass through unchanged. A fault in the parity FFT never reaches the outputs unless the flags also name a lane. If the flags name a lane that is healthy, the rebuilt value is still the right value.

The stored frame is released while the next frame is written. The buffer is a single read-first memory with one address counter, so the outputs of frame k come out as the samples of frame k+1 arrive.

Top module: `parity_fft_corrector`

## Requirements
- R1: One cycle after a cycle with `din_valid` high, `par_din_valid` is high and `par_din` equals the sum of the four signed lane inputs, sign-extended to IN_W+GUARD_W bits. In every other cycle `par_din_valid` is low.
- R2: After reset, and until a full frame of FRAME_LEN `fft_valid` samples has been stored, `dout_valid` stays low.
- R3: Sample j of frame k is output with `dout_valid` high exactly two clock edges after the edge that captures sample j of frame k+1.
- R4: The flags decode as bits {flag2, flag1, flag0}. flag0 covers lanes {0,1,2}, flag1 covers lanes {0,1,3} and flag2 covers lanes {0,2,3}. So 3'b111 names lane 0, 3'b011 names lane 1, 3'b101 names lane 2 and 3'b110 names lane 3.
- R5: A named lane's output is replaced by `par_q` minus the other three stored lane outputs, computed in two's complement and truncated to OUT_W bits.
- R6: When the flags are all low, or only one flag is high, every lane passes its stored value unchanged.
- R7: A `chk_valid` pulse applies its flags to the most recently completed frame. A pulse in the same cycle as the first sample of the following frame still applies to the completed frame. If no pulse arrives before that first sample, the frame is not corrected.
- R8: When the flags name a lane whose output was correct (a false alarm), the output of that lane still equals its correct value.
- R9: A corrupted `par_q` with flags that name no lane leaves all outputs unaffected.
- R10: A correction applies to one frame only. The next frame is not corrected unless a new pulse names a lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_valid | input | 1 | Lane input samples valid |
| din0 | input | IN_W | Lane 0 input sample (signed) |
| din1 | input | IN_W | Lane 1 input sample (signed) |
| din2 | input | IN_W | Lane 2 input sample (signed) |
| din3 | input | IN_W | Lane 3 input sample (signed) |
| par_din_valid | output | 1 | Parity FFT input valid |
| par_din | output | IN_W+GUARD_W | Parity FFT input, sum of the four lane inputs |
| fft_valid | input | 1 | FFT output samples valid |
| fft_q0 | input | OUT_W | Lane 0 FFT output |
| fft_q1 | input | OUT_W | Lane 1 FFT output |
| fft_q2 | input | OUT_W | Lane 2 FFT output |
| fft_q3 | input | OUT_W | Lane 3 FFT output |
| par_q | input | OUT_W+GUARD_W | Parity FFT output |
| chk_valid | input | 1 | Energy-check flags valid for the last completed frame |
| chk_flags | input | 3 | Energy-check failure flags {flag2, flag1, flag0} |
| dout_valid | output | 1 | Corrected output valid |
| dout0 | output | OUT_W | Lane 0 corrected output |
| dout1 | output | OUT_W | Lane 1 corrected output |
| dout2 | output | OUT_W | Lane 2 corrected output |
| dout3 | output | OUT_W | Lane 3 corrected output |

## Verification
The bench builds the block with FRAME_LEN = 8, IN_W = 12, OUT_W = 14 and GUARD_W = 2. The short frame lets the address wrap, the frame-boundary hand-over of the flags and the one-frame scope of a correction recur many times in a short run. It also reaches the case where a pulse coincides with the first sample of the next frame. The default widths keep the rebuilt value's truncation and the sign extension of the parity sum in play with errors large enough to leave the lane's normal range.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned CHECKS = 3;

  // Map the flag syndrome {flag2, flag1, flag0} to a one-hot lane select.
  // Group membership: flag0 -> {0,1,2}, flag1 -> {0,1,3}, flag2 -> {0,2,3}.
  function automatic logic [LANES-1:0] locate_lane(input logic [CHECKS-1:0] syn);
    logic [LANES-1:0] sel;
    unique case (syn)
      3'b111:  sel = 4'b0001;
      3'b011:  sel = 4'b0010;
      3'b101:  sel = 4'b0100;
      3'b110:  sel = 4'b1000;
      default: sel = 4'b0000;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/pfc_parity_sum.sv
module pfc_parity_sum #(
  parameter int unsigned IN_W    = 12,
  parameter int unsigned GUARD_W = 2,
  parameter int unsigned LANES   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [LANES*IN_W-1:0]     in_flat,
  output logic                      sum_valid,
  output logic [IN_W+GUARD_W-1:0]   sum_q
);

  localparam int unsigned SUM_W = IN_W + GUARD_W;

  logic [SUM_W-1:0] ext [LANES];
  logic [SUM_W-1:0] total;

  for (genvar l = 0; l < LANES; l++) begin : g_ext
    assign ext[l] = {{GUARD_W{in_flat[l*IN_W+IN_W-1]}}, in_flat[l*IN_W +: IN_W]};
  end

  always_comb begin
    total = '0;
    for (int l = 0; l < LANES; l++) begin
      total = total + ext[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_valid <= 1'b0;
      sum_q     <= '0;
    end else begin
      sum_valid <= in_valid;
      if (in_valid) begin
        sum_q <= total;
      end
    end
  end

endmodule

// File: rtl/pfc_frame_delay.sv
module pfc_frame_delay #(
  parameter int unsigned WIDTH     = 72,
  parameter int unsigned FRAME_LEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             frame_start,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);

  localparam int unsigned ADDR_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_LEN - 1);

  logic [WIDTH-1:0]  mem [FRAME_LEN];
  logic [ADDR_W-1:0] addr;
  logic              primed;

  assign frame_start = wr_en && (addr == '0);

  // Read-first single-port memory: the word of the previous frame leaves
  // as the word of the current frame takes its place.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      rd_data   <= mem[addr];
      mem[addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      primed   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= wr_en && primed;
      if (wr_en) begin
        if (addr == LAST) begin
          addr   <= '0;
          primed <= 1'b1;
        end else begin
          addr <= addr + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pfc_syndrome.sv
module pfc_syndrome
  import pfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic [CHECKS-1:0] chk_flags,
  input  logic              wr_en,
  input  logic              frame_start,
  output logic [LANES-1:0]  sel_q
);

  logic [CHECKS-1:0] pending;
  logic [CHECKS-1:0] eff_syn;
  logic [LANES-1:0]  active_sel;
  logic [LANES-1:0]  read_sel;

  // A pulse coinciding with the first sample of the next frame bypasses
  // the pending register.
  assign eff_syn  = chk_valid ? chk_flags : pending;
  assign read_sel = frame_start ? locate_lane(eff_syn) : active_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= '0;
      active_sel <= '0;
      sel_q      <= '0;
    end else begin
      if (frame_start) begin
        active_sel <= locate_lane(eff_syn);
        pending    <= '0;
      end else if (chk_valid) begin
        pending <= chk_flags;
      end
      if (wr_en) begin
        sel_q <= read_sel;
      end
    end
  end

endmodule

// File: rtl/pfc_rebuild.sv
module pfc_rebuild #(
  parameter int unsigned OUT_W   = 14,
  parameter int unsigned GUARD_W = 2,
  parameter int unsigned LANES   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [LANES*OUT_W-1:0]     lanes_flat,
  input  logic [OUT_W+GUARD_W-1:0]   par,
  input  logic [LANES-1:0]           sel,
  output logic                       out_valid,
  output logic [LANES*OUT_W-1:0]     out_flat
);

  localparam int unsigned PAR_W = OUT_W + GUARD_W;
  localparam int unsigned EXT_W = PAR_W + 2;

  logic [EXT_W-1:0] lane_ext [LANES];
  logic [EXT_W-1:0] lane_total;
  logic [EXT_W-1:0] par_ext;

  assign par_ext = {{(EXT_W-PAR_W){par[PAR_W-1]}}, par};

  for (genvar l = 0; l < LANES; l++) begin : g_ext
    assign lane_ext[l] = {{(EXT_W-OUT_W){lanes_flat[l*OUT_W+OUT_W-1]}},
                          lanes_flat[l*OUT_W +: OUT_W]};
  end

  always_comb begin
    lane_total = '0;
    for (int l = 0; l < LANES; l++) begin
      lane_total = lane_total + lane_ext[l];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [EXT_W-1:0] others;
    logic [EXT_W-1:0] rebuilt;
    logic [OUT_W-1:0] chosen;

    assign others  = lane_total - lane_ext[l];
    assign rebuilt = par_ext - others;
    assign chosen  = sel[l] ? rebuilt[OUT_W-1:0] : lanes_flat[l*OUT_W +: OUT_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        out_flat[l*OUT_W +: OUT_W] <= '0;
      end else if (in_valid) begin
        out_flat[l*OUT_W +: OUT_W] <= chosen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

endmodule

// File: rtl/parity_fft_corrector.sv
module parity_fft_corrector
  import pfc_pkg::*;
#(
  parameter int unsigned IN_W      = 12,
  parameter int unsigned OUT_W     = 14,
  parameter int unsigned GUARD_W   = 2,
  parameter int unsigned FRAME_LEN = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     din_valid,
  input  logic [IN_W-1:0]          din0,
  input  logic [IN_W-1:0]          din1,
  input  logic [IN_W-1:0]          din2,
  input  logic [IN_W-1:0]          din3,
  output logic                     par_din_valid,
  output logic [IN_W+GUARD_W-1:0]  par_din,
  input  logic                     fft_valid,
  input  logic [OUT_W-1:0]         fft_q0,
  input  logic [OUT_W-1:0]         fft_q1,
  input  logic [OUT_W-1:0]         fft_q2,
  input  logic [OUT_W-1:0]         fft_q3,
  input  logic [OUT_W+GUARD_W-1:0] par_q,
  input  logic                     chk_valid,
  input  logic [2:0]               chk_flags,
  output logic                     dout_valid,
  output logic [OUT_W-1:0]         dout0,
  output logic [OUT_W-1:0]         dout1,
  output logic [OUT_W-1:0]         dout2,
  output logic [OUT_W-1:0]         dout3
);

  localparam int unsigned PAR_W  = OUT_W + GUARD_W;
  localparam int unsigned LANE_W = LANES * OUT_W;
  localparam int unsigned WORD_W = LANE_W + PAR_W;

  logic [LANES*IN_W-1:0] din_flat;
  logic [WORD_W-1:0]     wr_word;
  logic [WORD_W-1:0]     rd_word;
  logic                  frame_start;
  logic                  rd_valid;
  logic [LANES-1:0]      stage_sel;
  logic [LANE_W-1:0]     out_flat;

  assign din_flat = {din3, din2, din1, din0};
  assign wr_word  = {par_q, fft_q3, fft_q2, fft_q1, fft_q0};

  pfc_parity_sum #(
    .IN_W    (IN_W),
    .GUARD_W (GUARD_W),
    .LANES   (LANES)
  ) i_sum (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (din_valid),
    .in_flat   (din_flat),
    .sum_valid (par_din_valid),
    .sum_q     (par_din)
  );

  pfc_frame_delay #(
    .WIDTH     (WORD_W),
    .FRAME_LEN (FRAME_LEN)
  ) i_delay (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (fft_valid),
    .wr_data     (wr_word),
    .frame_start (frame_start),
    .rd_valid    (rd_valid),
    .rd_data     (rd_word)
  );

  pfc_syndrome i_syn (
    .clk         (clk),
    .rst         (rst),
    .chk_valid   (chk_valid),
    .chk_flags   (chk_flags),
    .wr_en       (fft_valid),
    .frame_start (frame_start),
    .sel_q       (stage_sel)
  );

  pfc_rebuild #(
    .OUT_W   (OUT_W),
    .GUARD_W (GUARD_W),
    .LANES   (LANES)
  ) i_fix (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (rd_valid),
    .lanes_flat (rd_word[LANE_W-1:0]),
    .par        (rd_word[WORD_W-1:LANE_W]),
    .sel        (stage_sel),
    .out_valid  (dout_valid),
    .out_flat   (out_flat)
  );

  assign dout0 = out_flat[0*OUT_W +: OUT_W];
  assign dout1 = out_flat[1*OUT_W +: OUT_W];
  assign dout2 = out_flat[2*OUT_W +: OUT_W];
  assign dout3 = out_flat[3*OUT_W +: OUT_W];

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int unsigned IN_W      = 12,
  parameter int unsigned GUARD_W   = 2,
  parameter int unsigned FRAME_LEN = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    din_valid,
  input logic [IN_W-1:0]         din0,
  input logic [IN_W-1:0]         din1,
  input logic [IN_W-1:0]         din2,
  input logic [IN_W-1:0]         din3,
  input logic                    par_din_valid,
  input logic [IN_W+GUARD_W-1:0] par_din,
  input logic                    fft_valid,
  input logic                    dout_valid,
  input logic [3:0]              stage_sel
);

  localparam int unsigned SUM_W = IN_W + GUARD_W;
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);

  logic [SUM_W-1:0] ref_sum;
  logic [CNT_W-1:0] seen;

  assign ref_sum = SUM_W'($signed(din0)) + SUM_W'($signed(din1))
                 + SUM_W'($signed(din2)) + SUM_W'($signed(din3));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
    end else if (fft_valid && seen != CNT_W'(FRAME_LEN)) begin
      seen <= seen + 1'b1;
    end
  end

  p_par_valid_r1: assert property (@(posedge clk) disable iff (rst)
    par_din_valid == $past(din_valid));

  p_par_sum_r1: assert property (@(posedge clk) disable iff (rst)
    din_valid |=> par_din == $past(ref_sum));

  p_no_early_out_r2: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> seen == CNT_W'(FRAME_LEN));

  p_out_latency_r3: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> $past(fft_valid, 2));

  p_one_lane_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_sel));

endmodule

bind parity_fft_corrector pfc_checker #(
  .IN_W      (IN_W),
  .GUARD_W   (GUARD_W),
  .FRAME_LEN (FRAME_LEN)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .din_valid     (din_valid),
  .din0          (din0),
  .din1          (din1),
  .din2          (din2),
  .din3          (din3),
  .par_din_valid (par_din_valid),
  .par_din       (par_din),
  .fft_valid     (fft_valid),
  .dout_valid    (dout_valid),
  .stage_sel     (stage_sel)
);

// File: tb/test_parity_fft_corrector.sv
`timescale 1ns/1ps
module test_parity_fft_corrector;

  localparam int IW = 12;
  localparam int OW = 14;
  localparam int GW = 2;
  localparam int N  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din_valid = 1'b0;
  logic [IW-1:0] din0 = '0, din1 = '0, din2 = '0, din3 = '0;
  logic par_din_valid;
  logic [IW+GW-1:0] par_din;
  logic fft_valid = 1'b0;
  logic [OW-1:0] fft_q0 = '0, fft_q1 = '0, fft_q2 = '0, fft_q3 = '0;
  logic [OW+GW-1:0] par_q = '0;
  logic chk_valid = 1'b0;
  logic [2:0] chk_flags = '0;
  logic dout_valid;
  logic [OW-1:0] dout0, dout1, dout2, dout3;

  always #2 clk = ~clk;

  parity_fft_corrector #(
    .IN_W(IW), .OUT_W(OW), .GUARD_W(GW), .FRAME_LEN(N)
  ) i_parity_fft_corrector (
    .clk(clk), .rst(rst),
    .din_valid(din_valid), .din0(din0), .din1(din1), .din2(din2), .din3(din3),
    .par_din_valid(par_din_valid), .par_din(par_din),
    .fft_valid(fft_valid), .fft_q0(fft_q0), .fft_q1(fft_q1), .fft_q2(fft_q2),
    .fft_q3(fft_q3), .par_q(par_q),
    .chk_valid(chk_valid), .chk_flags(chk_flags),
    .dout_valid(dout_valid), .dout0(dout0), .dout1(dout1), .dout2(dout2),
    .dout3(dout3)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int    prev_raw [4][N];
  int    prev_par [N];
  int    prev_sel = -1;
  bit    prev_ok  = 1'b0;
  string prev_tag = "R2";

  task automatic check(input bit ok, input string req, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // R4 table: {flag2,flag1,flag0}; 111->lane0, 011->lane1, 101->lane2, 110->lane3.
  function automatic int exp_lane(input logic [2:0] f);
    case (f)
      3'b111:  return 0;
      3'b011:  return 1;
      3'b101:  return 2;
      3'b110:  return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [OW-1:0] expected(input int lane, input int j);
    int v;
    if (lane == prev_sel) begin
      v = prev_par[j];
      for (int o = 0; o < 4; o++) if (o != lane) v -= prev_raw[o][j];
    end else begin
      v = prev_raw[lane][j];
    end
    return v[OW-1:0];
  endfunction

  // Streams one frame. Each sample also releases sample j of the previous
  // frame, which is checked two edges later (R3).
  task automatic stream_frame(input int err_lane, input bit err_par,
                              input bit co_chk, input logic [2:0] co_flags,
                              input string tag);
    int raw [4][N];
    int par [N];
    if (co_chk) prev_sel = exp_lane(co_flags);
    for (int j = 0; j < N; j++) begin
      int t [4];
      int d [4];
      int s;
      logic [IW+GW-1:0] exp_par;
      logic [OW-1:0] got [4];
      s = 0;
      for (int l = 0; l < 4; l++) begin
        t[l] = $urandom_range(2000) - 1000;
        d[l] = $urandom_range(4000) - 2000;
        s += t[l];
        raw[l][j] = (l == err_lane) ? t[l] + 3000 : t[l];
      end
      par[j] = err_par ? s + 5000 : s;
      din0 = d[0][IW-1:0]; din1 = d[1][IW-1:0];
      din2 = d[2][IW-1:0]; din3 = d[3][IW-1:0];
      din_valid = 1'b1;
      fft_q0 = raw[0][j][OW-1:0]; fft_q1 = raw[1][j][OW-1:0];
      fft_q2 = raw[2][j][OW-1:0]; fft_q3 = raw[3][j][OW-1:0];
      par_q = par[j][OW+GW-1:0];
      fft_valid = 1'b1;
      chk_valid = co_chk && (j == 0);
      chk_flags = co_flags;
      @(posedge clk);
      @(negedge clk);
      din_valid = 1'b0; fft_valid = 1'b0; chk_valid = 1'b0;
      exp_par = IW'(0);
      exp_par = (IW+GW)'(d[0] + d[1] + d[2] + d[3]);
      check(par_din_valid === 1'b1 && par_din === exp_par, "R1",
            $sformatf("par_din act %0h/%0b exp %0h/1", par_din, par_din_valid, exp_par));
      @(posedge clk);
      @(negedge clk);
      check(par_din_valid === 1'b0, "R1",
            $sformatf("par_din_valid act %0b exp 0", par_din_valid));
      got[0] = dout0; got[1] = dout1; got[2] = dout2; got[3] = dout3;
      if (!prev_ok) begin
        check(dout_valid === 1'b0, "R2",
              $sformatf("dout_valid act %0b exp 0", dout_valid));
      end else begin
        bit ok;
        ok = (dout_valid === 1'b1);
        for (int l = 0; l < 4; l++) ok &= (got[l] === expected(l, j));
        check(ok, {prev_tag, " R3"},
              $sformatf("sample %0d act v%0b %0h %0h %0h %0h exp v1 %0h %0h %0h %0h",
                        j, dout_valid, got[0], got[1], got[2], got[3],
                        expected(0, j), expected(1, j), expected(2, j), expected(3, j)));
      end
    end
    for (int j = 0; j < N; j++) begin
      for (int l = 0; l < 4; l++) prev_raw[l][j] = raw[l][j];
      prev_par[j] = par[j];
    end
    prev_ok  = 1'b1;
    prev_sel = -1;
    prev_tag = tag;
  endtask

  task automatic pulse_flags(input logic [2:0] f);
    @(negedge clk);
    chk_valid = 1'b1;
    chk_flags = f;
    @(posedge clk);
    @(negedge clk);
    chk_valid = 1'b0;
    prev_sel = exp_lane(f);
    check(dout_valid === 1'b0, "R3",
          $sformatf("dout_valid between frames act %0b exp 0", dout_valid));
  endtask

  task automatic t_reset;
    check(dout_valid === 1'b0 && par_din_valid === 1'b0 && dout0 === '0, "R2",
          $sformatf("reset act v%0b pv%0b d0 %0h exp 0 0 0", dout_valid, par_din_valid, dout0));
  endtask

  task automatic t_first_frame;     // R2: nothing released during the first frame
    stream_frame(-1, 1'b0, 1'b0, 3'b000, "R6");
  endtask

  task automatic t_lane(input int lane, input logic [2:0] f);   // R4 R5
    stream_frame(lane, 1'b0, 1'b0, 3'b000, "R4 R5");
    pulse_flags(f);
    stream_frame(-1, 1'b0, 1'b0, 3'b000, "R10");
  endtask

  task automatic t_single_flag;     // R6: one raised flag names no lane
    stream_frame(1, 1'b0, 1'b0, 3'b000, "R6");
    pulse_flags(3'b010);
    stream_frame(-1, 1'b0, 1'b0, 3'b000, "R6");
  endtask

  task automatic t_false_alarm;     // R8
    stream_frame(-1, 1'b0, 1'b0, 3'b000, "R8");
    pulse_flags(3'b101);
    stream_frame(-1, 1'b0, 1'b0, 3'b000, "R6");
  endtask

  task automatic t_parity_fault;    // R9
    stream_frame(-1, 1'b1, 1'b0, 3'b000, "R9");
    pulse_flags(3'b000);
    stream_frame(-1, 1'b0, 1'b0, 3'b000, "R6");
  endtask

  task automatic t_coincident;      // R7: pulse together with next frame's first sample
    stream_frame(3, 1'b0, 1'b0, 3'b000, "R7");
    stream_frame(-1, 1'b0, 1'b1, 3'b110, "R6");
  endtask

  task automatic t_missing;         // R7: no pulse means no correction
    stream_frame(0, 1'b0, 1'b0, 3'b000, "R7");
    stream_frame(-1, 1'b0, 1'b0, 3'b000, "R6");
  endtask

  task automatic t_once;            // R10: the same fault one frame later, unflagged
    stream_frame(2, 1'b0, 1'b0, 3'b000, "R4 R5");
    pulse_flags(3'b101);
    stream_frame(2, 1'b0, 1'b0, 3'b000, "R10");
    stream_frame(-1, 1'b0, 1'b0, 3'b000, "R6");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_frame();
    pulse_flags(3'b000);
    t_lane(0, 3'b111);
    t_lane(1, 3'b011);
    t_lane(2, 3'b101);
    t_lane(3, 3'b110);
    t_single_flag();
    t_false_alarm();
    t_parity_fault();
    t_coincident();
    t_missing();
    t_once();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act hung exp finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule